// File: doc/BRIEF.md
# External Memory Burst Sequencer

This block runs the external memory bus for a single chip-select region. An internal master hands it one request at a time: a single word read or write, or a burst read. The block drives chip select, an address-phase marker, address, outgoing data, four lane strobes and a burst-in-progress line. It counts wait states and data beats, gathers the incoming data into words of the internal bus width, and pulses an acknowledge with each gathered chunk.

The region's configuration arrives as static inputs. They set the port width, whether the address is also placed on the data lines, the burst length, whether the strobes act as write enables or byte enables, and whether burst-in-progress is held or pulsed. A global 16-bit bus mode forces a 16-bit port. Two wait counts set the timing: one for the first beat and one for every later beat. The internal bus width (32 or 64) is a design parameter.

Top module: `xbus_burst_ctrl`

## Requirements
- R1: The effective port is 16 bits when `cfg_port16` or `bus16_mode` is 1, else 32 bits. A 16-bit port moves data only on `ext_dout/ext_din[31:16]` and strobe bits [3:2], and `ext_addr` advances by 2 per beat; a 32-bit port advances by 4. `ext_strobe[i]` covers data bits [8i+7:8i].
- R2: A burst moves 4 words when `cfg_bl4`=1 or IBUS_W=32, and 8 words when `cfg_bl4`=0 with IBUS_W=64. Beats are words on a 32-bit port and twice that on a 16-bit port. A single moves one word (1 or 2 beats).
- R3: With `bus16_mode`=1, the value of `cfg_port16` has no effect; the region behaves as a 16-bit port.
- R4: In the address-phase cycle (`ext_ts`=1), `cfg_admux`=1 drives `ext_doe`=1 and `ext_dout` = zero-extended start address; with `cfg_admux`=0 the data lines are not driven in that cycle.
- R5: The address phase lasts one cycle. The first beat falls `cfg_first_wait` cycles after it, and each later beat `cfg_burst_wait` cycles after the previous beat. So chip select is high for 2 + first_wait + (beats-1)*(burst_wait+1) cycles.
- R6: With `cfg_strobe_be`=0 the strobes are write enables. During data cycles of a write they carry the written lanes of `req_be`; on reads they stay 0.
- R7: With `cfg_strobe_be`=1 the strobes are byte enables. During data cycles a read asserts every lane of the port (4'b1111 or 4'b1100), and a write asserts the lanes given by `req_be`.
- R8: With `cfg_toggle`=0, `ext_bip` is 1 on every data cycle of a burst except the final beat's cycle. It is never 1 for singles or outside chip select.
- R9: With `cfg_toggle`=1, `ext_bip` is 1 only on the `cfg_burst_wait`+1 cycles that end just before each later beat: a non-final beat's own cycle and the wait cycles that follow it.
- R10: On a 16-bit port a word moves as two beats, upper halfword first. Write data for beat 0 is `req_wdata[31:16]` and for beat 1 is `req_wdata[15:0]`, both on `ext_dout[31:16]`. The read word is {first beat, second beat}.
- R11: `rsp_valid` pulses the cycle after the beat that completes a chunk. With IBUS_W=64 a burst returns word 2c in bits [31:0] and word 2c+1 in bits [63:32] of chunk c. A single read returns its word in [31:0] with the upper bits 0. A write returns one pulse with data 0 after its last beat.
- R12: Bursts are always reads. `req_write` is ignored when `req_burst`=1: `ext_wr` stays 0 and no write data is driven.
- R13: `req_ready` is 1 only while no cycle is running. A request is taken when `req_valid` and `req_ready` are both 1. `ext_ts` is high for exactly the one cycle after acceptance, and `ext_cs` stays high from then through the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_write | input | 1 | 1 = write (singles only) |
| req_burst | input | 1 | 1 = burst read |
| req_addr | input | AW | Start byte address |
| req_wdata | input | 32 | Write word |
| req_be | input | 4 | Byte lanes of the write word |
| rsp_valid | output | 1 | Acknowledge with data chunk |
| rsp_data | output | IBUS_W | Gathered read data |
| cfg_port16 | input | 1 | 1 = 16-bit port |
| cfg_admux | input | 1 | Address on data lines in address phase |
| cfg_bl4 | input | 1 | 1 = 4-word burst, 0 = 8-word burst |
| cfg_strobe_be | input | 1 | 0 = write enables, 1 = byte enables |
| cfg_toggle | input | 1 | 0 = hold burst-in-progress, 1 = pulse it |
| bus16_mode | input | 1 | Global 16-bit bus mode |
| cfg_first_wait | input | WAIT_W | Wait cycles before the first beat |
| cfg_burst_wait | input | WAIT_W | Wait cycles before each later beat |
| ext_cs | output | 1 | Chip select |
| ext_ts | output | 1 | Address-phase marker |
| ext_wr | output | 1 | Write cycle in progress |
| ext_addr | output | AW | External address |
| ext_dout | output | 32 | Data driven to memory |
| ext_doe | output | 1 | Data output enable |
| ext_din | input | 32 | Data from memory |
| ext_strobe | output | 4 | Write or byte enables |
| ext_bip | output | 1 | Burst data in progress |

## Verification
The bench targets beat counts where port width and burst length combine (16 beats on a forced 16-bit bus, 8 on a 16-bit 4-word burst). A design that ignored the global mode or the width would end chip select too early and return the wrong number of acknowledges. It compares the two burst-in-progress modes with zero and non-zero wait counts. A sequencer that kept the line high on the final beat, or raised it during the first wait in pulse mode, shows up cycle by cycle. Halfword order and the pairing of words into 64-bit chunks are checked against address-coded memory data, so a swapped half or a swapped word gives the wrong value. A burst request with the write bit set, and a reset in mid-burst, confirm that no write and no stale cycle escape.

// File: rtl/xbb_pkg.sv
package xbb_pkg;

  localparam int XBB_BEAT_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} xbb_state_e;

  // Number of external beats for one request.
  function automatic logic [XBB_BEAT_W-1:0] xbb_beats(input logic eff16, input logic bl4,
                                                      input logic burst, input int ibus_w);
    logic [XBB_BEAT_W-1:0] words;
    if (!burst)                     words = XBB_BEAT_W'(1);
    else if (ibus_w == 32 || bl4)   words = XBB_BEAT_W'(4);
    else                            words = XBB_BEAT_W'(8);
    return eff16 ? (words << 1) : words;
  endfunction

  // Lane strobes during a data cycle.
  function automatic logic [3:0] xbb_strobe(input logic eff16, input logic be_mode, input logic wr,
                                            input logic second_half, input logic [3:0] be);
    logic [3:0] s;
    if (wr)           s = eff16 ? (second_half ? {be[1:0], 2'b00} : {be[3:2], 2'b00}) : be;
    else if (be_mode) s = eff16 ? 4'b1100 : 4'b1111;
    else              s = 4'b0000;
    return s;
  endfunction

endpackage

// File: rtl/xbb_sequencer.sv
module xbb_sequencer
  import xbb_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int BW     = XBB_BEAT_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BW-1:0]     nbeats,
  input  logic [WAIT_W-1:0] first_wait,
  input  logic [WAIT_W-1:0] burst_wait,
  output xbb_state_e        state,
  output logic [BW-1:0]     beat_idx,
  output logic              beat_fire,
  output logic              last_beat,
  output logic              in_wait
);
  logic [WAIT_W-1:0] cnt;
  logic [BW-1:0]     total;

  assign beat_fire = (state == ST_DATA) && (cnt == '0);
  assign in_wait   = (state == ST_DATA) && (cnt != '0);
  assign last_beat = (beat_idx == total - BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      total    <= '0;
      beat_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_ADDR;
          total    <= nbeats;
          beat_idx <= '0;
        end
        ST_ADDR: begin
          state <= ST_DATA;
          cnt   <= first_wait;
        end
        ST_DATA: begin
          if (beat_fire) begin
            if (last_beat) state <= ST_IDLE;
            else begin
              beat_idx <= beat_idx + BW'(1);
              cnt      <= burst_wait;
            end
          end else begin
            cnt <= cnt - WAIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbb_drive.sv
module xbb_drive
  import xbb_pkg::*;
#(
  parameter int AW = 24,
  parameter int BW = XBB_BEAT_W
)(
  input  xbb_state_e    state,
  input  logic          eff16,
  input  logic          wr,
  input  logic          burst,
  input  logic          admux,
  input  logic          be_mode,
  input  logic          toggle,
  input  logic          beat_fire,
  input  logic          last_beat,
  input  logic          in_wait,
  input  logic [BW-1:0] beat_idx,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [3:0]    be,
  output logic          cs,
  output logic          ts,
  output logic          wr_o,
  output logic          doe,
  output logic          bip,
  output logic [31:0]   dout,
  output logic [3:0]    strobe
);
  logic in_data;
  assign in_data = (state == ST_DATA);

  always_comb begin
    cs     = (state != ST_IDLE);
    ts     = (state == ST_ADDR);
    wr_o   = cs && wr;
    doe    = 1'b0;
    dout   = '0;
    strobe = '0;
    bip    = 1'b0;
    if (ts && admux) begin
      doe  = 1'b1;
      dout = 32'(addr);
    end
    if (in_data) begin
      strobe = xbb_strobe(eff16, be_mode, wr, beat_idx[0], be);
      if (wr) begin
        doe  = 1'b1;
        dout = eff16 ? {(beat_idx[0] ? wdata[15:0] : wdata[31:16]), 16'h0000} : wdata;
      end
      if (burst)
        bip = toggle ? (((beat_idx != '0) && in_wait) || (beat_fire && !last_beat))
                     : !(beat_fire && last_beat);
    end
  end
endmodule

// File: rtl/xbb_gather.sv
module xbb_gather #(
  parameter int IBUS_W = 64,
  parameter int BW     = 5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_fire,
  input  logic              last_beat,
  input  logic              eff16,
  input  logic              wr,
  input  logic              burst,
  input  logic [BW-1:0]     beat_idx,
  input  logic [31:0]       din,
  output logic              rsp_valid,
  output logic [IBUS_W-1:0] rsp_data
);
  logic [15:0] hi_q;
  logic        word_done;
  logic        word_odd;
  logic [31:0] word;

  assign word_done = beat_fire && (!eff16 || beat_idx[0]);
  assign word_odd  = eff16 ? beat_idx[1] : beat_idx[0];
  assign word      = eff16 ? {hi_q, din[31:16]} : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else if (beat_fire && eff16 && !beat_idx[0]) hi_q <= din[31:16];
  end

  generate
    if (IBUS_W == 64) begin : g_wide
      logic [31:0] low_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rsp_valid <= 1'b0;
          rsp_data  <= '0;
          low_q     <= '0;
        end else begin
          rsp_valid <= 1'b0;
          if (wr) begin
            if (beat_fire && last_beat) begin
              rsp_valid <= 1'b1;
              rsp_data  <= '0;
            end
          end else if (word_done) begin
            if (!burst) begin
              rsp_valid <= 1'b1;
              rsp_data  <= {32'h0, word};
            end else if (!word_odd) begin
              low_q <= word;
            end else begin
              rsp_valid <= 1'b1;
              rsp_data  <= {word, low_q};
            end
          end
        end
      end
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rsp_valid <= 1'b0;
          rsp_data  <= '0;
        end else begin
          rsp_valid <= 1'b0;
          if (wr) begin
            if (beat_fire && last_beat) begin
              rsp_valid <= 1'b1;
              rsp_data  <= '0;
            end
          end else if (word_done) begin
            rsp_valid <= 1'b1;
            rsp_data  <= word;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xbus_burst_ctrl.sv
module xbus_burst_ctrl
  import xbb_pkg::*;
#(
  parameter int IBUS_W = 64,
  parameter int AW     = 24,
  parameter int WAIT_W = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  output logic [IBUS_W-1:0] rsp_data,
  input  logic              cfg_port16,
  input  logic              cfg_admux,
  input  logic              cfg_bl4,
  input  logic              cfg_strobe_be,
  input  logic              cfg_toggle,
  input  logic              bus16_mode,
  input  logic [WAIT_W-1:0] cfg_first_wait,
  input  logic [WAIT_W-1:0] cfg_burst_wait,
  output logic              ext_cs,
  output logic              ext_ts,
  output logic              ext_wr,
  output logic [AW-1:0]     ext_addr,
  output logic [31:0]       ext_dout,
  output logic              ext_doe,
  input  logic [31:0]       ext_din,
  output logic [3:0]        ext_strobe,
  output logic              ext_bip
);
  localparam int BW = XBB_BEAT_W;

  xbb_state_e    state;
  logic [BW-1:0] beat_idx;
  logic          beat_fire;
  logic          last_beat;
  logic          in_wait;
  logic          start;
  logic          eff16_in;
  logic [BW-1:0] nbeats_in;

  logic          eff16_q;
  logic          wr_q;
  logic          burst_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q;
  logic [3:0]    be_q;

  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;
  assign eff16_in  = cfg_port16 | bus16_mode;
  assign nbeats_in = xbb_beats(eff16_in, cfg_bl4, req_burst, IBUS_W);
  assign ext_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff16_q <= 1'b0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start) begin
      eff16_q <= eff16_in;
      wr_q    <= req_write && !req_burst;
      burst_q <= req_burst;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end else if (beat_fire && !last_beat) begin
      addr_q <= addr_q + (eff16_q ? AW'(2) : AW'(4));
    end
  end

  xbb_sequencer #(.WAIT_W(WAIT_W), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .nbeats(nbeats_in),
    .first_wait(cfg_first_wait), .burst_wait(cfg_burst_wait),
    .state(state), .beat_idx(beat_idx), .beat_fire(beat_fire),
    .last_beat(last_beat), .in_wait(in_wait)
  );

  xbb_drive #(.AW(AW), .BW(BW)) u_drive (
    .state(state), .eff16(eff16_q), .wr(wr_q), .burst(burst_q), .admux(cfg_admux),
    .be_mode(cfg_strobe_be), .toggle(cfg_toggle), .beat_fire(beat_fire),
    .last_beat(last_beat), .in_wait(in_wait), .beat_idx(beat_idx), .addr(addr_q),
    .wdata(wdata_q), .be(be_q), .cs(ext_cs), .ts(ext_ts), .wr_o(ext_wr),
    .doe(ext_doe), .bip(ext_bip), .dout(ext_dout), .strobe(ext_strobe)
  );

  xbb_gather #(.IBUS_W(IBUS_W), .BW(BW)) u_gather (
    .clk(clk), .rst_n(rst_n), .beat_fire(beat_fire), .last_beat(last_beat),
    .eff16(eff16_q), .wr(wr_q), .burst(burst_q), .beat_idx(beat_idx),
    .din(ext_din), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/xbb_checker.sv
module xbb_checker #(
  parameter int AW = 24
)(
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          ext_cs,
  input logic          ext_ts,
  input logic          ext_wr,
  input logic          ext_doe,
  input logic [31:0]   ext_dout,
  input logic [AW-1:0] ext_addr,
  input logic [3:0]    ext_strobe,
  input logic          ext_bip,
  input logic          rsp_valid,
  input logic          cfg_admux,
  input logic          cfg_strobe_be,
  input logic          beat_fire,
  input logic          last_beat,
  input logic          eff16_q,
  input logic          burst_q
);
  p_bip_needs_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bip |-> ext_cs);
  p_single_no_bip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs && !burst_q) |-> !ext_bip);
  p_bip_drops_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && last_beat) |-> !ext_bip);
  p_ts_one_cycle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ts |=> (!ext_ts && ext_cs));
  p_ready_when_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ext_cs);
  p_addr_on_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ts && cfg_admux) |-> (ext_doe && ext_dout == 32'(ext_addr)));
  p_no_addr_on_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ts && !cfg_admux) |-> !ext_doe);
  p_we_quiet_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs && !ext_wr && !cfg_strobe_be) |-> (ext_strobe == 4'b0000));
  p_upper_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs && eff16_q) |-> (ext_strobe[1:0] == 2'b00));
  p_burst_never_writes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs && burst_q) |-> !ext_wr);
  p_ack_follows_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(beat_fire));
endmodule

bind xbus_burst_ctrl xbb_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ext_cs(ext_cs), .ext_ts(ext_ts),
  .ext_wr(ext_wr), .ext_doe(ext_doe), .ext_dout(ext_dout), .ext_addr(ext_addr),
  .ext_strobe(ext_strobe), .ext_bip(ext_bip), .rsp_valid(rsp_valid),
  .cfg_admux(cfg_admux), .cfg_strobe_be(cfg_strobe_be), .beat_fire(beat_fire),
  .last_beat(last_beat), .eff16_q(eff16_q), .burst_q(burst_q)
);

// File: tb/tb_xbus_burst_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_burst_ctrl;
  localparam int IBUS_W = 64;
  localparam int AW     = 24;
  localparam int WAIT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 0, req_write = 0, req_burst = 0;
  logic              req_ready;
  logic [AW-1:0]     req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic [3:0]        req_be = '0;
  logic              rsp_valid;
  logic [IBUS_W-1:0] rsp_data;
  logic cfg_port16 = 0, cfg_admux = 0, cfg_bl4 = 1, cfg_strobe_be = 0, cfg_toggle = 0, bus16_mode = 0;
  logic [WAIT_W-1:0] cfg_first_wait = '0, cfg_burst_wait = '0;
  logic              ext_cs, ext_ts, ext_wr, ext_doe, ext_bip;
  logic [AW-1:0]     ext_addr;
  logic [31:0]       ext_dout, ext_din;
  logic [3:0]        ext_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [31:0] din_of(input logic [AW-1:0] a);
    return {4'hC, a[11:0], 4'h5, a[11:0]};
  endfunction

  assign ext_din = din_of(ext_addr);

  xbus_burst_ctrl #(.IBUS_W(IBUS_W), .AW(AW), .WAIT_W(WAIT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cfg_port16(cfg_port16), .cfg_admux(cfg_admux), .cfg_bl4(cfg_bl4),
    .cfg_strobe_be(cfg_strobe_be), .cfg_toggle(cfg_toggle), .bus16_mode(bus16_mode),
    .cfg_first_wait(cfg_first_wait), .cfg_burst_wait(cfg_burst_wait),
    .ext_cs(ext_cs), .ext_ts(ext_ts), .ext_wr(ext_wr), .ext_addr(ext_addr),
    .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din),
    .ext_strobe(ext_strobe), .ext_bip(ext_bip)
  );

  typedef struct packed {
    logic p16, b16, bl4, wr, burst, bemode, tog, admux;
    logic [3:0] fw, bw, be;
    logic [23:0] addr;
    logic [4:0] nbeats;
    logic [3:0] nacks;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd2,4'd0,4'hF, 24'h000100, 5'd1,  4'd1},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 4'd1,4'd0,4'h6, 24'h000204, 5'd1,  4'd1},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 4'd0,4'd0,4'hF, 24'h000310, 5'd2,  4'd1},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 4'd1,4'd2,4'hB, 24'h000420, 5'd2,  4'd1},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 4'd1,4'd1,4'hF, 24'h000500, 5'd4,  4'd2},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 4'd2,4'd1,4'hF, 24'h000600, 5'd8,  4'd4},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 4'd0,4'd0,4'hF, 24'h000700, 5'd8,  4'd2},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 4'd1,4'd2,4'hF, 24'h000800, 5'd16, 4'd4},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 4'd0,4'd0,4'hF, 24'h000900, 5'd4,  4'd2},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 4'd3,4'd1,4'h5, 24'h000A04, 5'd2,  4'd1},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 4'd3,4'd2,4'hF, 24'h000B00, 5'd8,  4'd2}
  };
  localparam logic [31:0] WDATA = 32'hA1B2_C3D4;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input vec_t v, input int w);
    logic [AW-1:0] a;
    logic [31:0] h, l;
    a = v.addr + AW'(4 * w);
    if (v.p16 || v.b16) begin
      h = din_of(a);
      l = din_of(a + AW'(2));
      return {h[31:16], l[31:16]};
    end
    return din_of(a);
  endfunction

  function automatic logic [63:0] chunk_of(input vec_t v, input int c);
    if (v.wr && !v.burst) return 64'h0;
    if (!v.burst) return {32'h0, word_of(v, 0)};
    return {word_of(v, 2 * c + 1), word_of(v, 2 * c)};
  endfunction

  task automatic run_vec(input vec_t v, input int id);
    logic e16, wr_eff, last, exp_bip;
    int step, j, k, rem, jj, ncs, nack;
    logic [3:0] exp_s;
    logic [31:0] exp_d;
    e16 = v.p16 | v.b16;
    wr_eff = v.wr & !v.burst;
    step = e16 ? 2 : 4;
    @(negedge clk);
    cfg_port16 = v.p16; bus16_mode = v.b16; cfg_bl4 = v.bl4; cfg_strobe_be = v.bemode;
    cfg_toggle = v.tog; cfg_admux = v.admux; cfg_first_wait = v.fw; cfg_burst_wait = v.bw;
    req_write = v.wr; req_burst = v.burst; req_be = v.be; req_addr = v.addr; req_wdata = WDATA;
    req_valid = 1'b1;
    chk($sformatf("R13 ready before vec %0d", id), 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk($sformatf("R13 address phase vec %0d", id), {62'd0, ext_cs, ext_ts}, 64'd3);
    chk($sformatf("R13 busy vec %0d", id), 64'(req_ready), 64'd0);
    if (v.admux)
      chk($sformatf("R4 address on data vec %0d", id), {31'd0, ext_doe, ext_dout}, {31'd0, 1'b1, 8'h00, v.addr});
    else
      chk($sformatf("R4 data idle in address phase vec %0d", id), 64'(ext_doe), 64'd0);
    ncs = 1; nack = 0; j = 0;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        chk($sformatf("R11 chunk %0d vec %0d", nack, id), rsp_data, chunk_of(v, nack));
        nack++;
      end
      if (!ext_cs) break;
      ncs++;
      if (j <= int'(v.fw)) begin k = 0; rem = int'(v.fw) - j; end
      else begin
        jj = j - int'(v.fw) - 1;
        k = 1 + jj / (int'(v.bw) + 1);
        rem = int'(v.bw) - (jj % (int'(v.bw) + 1));
      end
      last = (k == int'(v.nbeats) - 1);
      chk($sformatf("R1 R3 beat address vec %0d cyc %0d", id, j), 64'(ext_addr), 64'(v.addr + AW'(k * step)));
      chk($sformatf("R12 write line vec %0d cyc %0d", id, j), 64'(ext_wr), 64'(wr_eff));
      if (wr_eff) exp_s = e16 ? ((k % 2 == 1) ? {v.be[1:0], 2'b00} : {v.be[3:2], 2'b00}) : v.be;
      else exp_s = v.bemode ? (e16 ? 4'b1100 : 4'b1111) : 4'b0000;
      chk($sformatf("R6 R7 strobes vec %0d cyc %0d", id, j), 64'(ext_strobe), 64'(exp_s));
      if (!v.burst) exp_bip = 1'b0;
      else if (v.tog) exp_bip = (k != 0 && rem != 0) || (rem == 0 && !last);
      else exp_bip = !(rem == 0 && last);
      chk($sformatf("%s burst line vec %0d cyc %0d", v.tog ? "R9" : "R8", id, j), 64'(ext_bip), 64'(exp_bip));
      if (wr_eff) begin
        exp_d = e16 ? {((k % 2 == 1) ? WDATA[15:0] : WDATA[31:16]), 16'h0} : WDATA;
        chk($sformatf("R10 write data vec %0d cyc %0d", id, j), {31'd0, ext_doe, ext_dout}, {31'd0, 1'b1, exp_d});
      end else begin
        chk($sformatf("R12 no drive on read vec %0d cyc %0d", id, j), 64'(ext_doe), 64'd0);
      end
      j++;
      if (j > 400) begin
        chk($sformatf("R5 cycle ends vec %0d", id), 64'd0, 64'd1);
        break;
      end
    end
    chk($sformatf("R2 R5 select length vec %0d", id), 64'(ncs),
        64'(2 + int'(v.fw) + (int'(v.nbeats) - 1) * (int'(v.bw) + 1)));
    chk($sformatf("R11 ack count vec %0d", id), 64'(nack), 64'(v.nacks));
    chk($sformatf("R13 ready after vec %0d", id), 64'(req_ready), 64'd1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R13, R8)
    chk("R13 reset ready", 64'(req_ready), 64'd1);
    chk("R13 reset outputs", {58'd0, ext_cs, ext_ts, ext_doe, ext_bip, rsp_valid, |ext_strobe}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 idle after reset", {62'd0, req_ready, ext_cs}, 64'd2);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // Reset during a long burst: everything returns idle (R13, R8)
    @(negedge clk);
    cfg_port16 = 0; bus16_mode = 1; cfg_bl4 = 0; cfg_toggle = 0; cfg_admux = 0;
    cfg_first_wait = 4'd1; cfg_burst_wait = 4'd2;
    req_burst = 1; req_write = 0; req_addr = 24'h000C00; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (6) @(negedge clk);
    chk("R8 burst line mid burst", 64'(ext_bip), 64'd1);
    rst_n = 1'b0;
    #1;
    chk("R13 reset mid burst", {61'd0, ext_cs, ext_bip, rsp_valid}, 64'd0);
    chk("R13 ready after mid reset", 64'(req_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    run_vec(VECS[0], 100);
    run_vec(VECS[6], 101);

    done = 1;
    finish_run();
  end
endmodule